// File: doc/BRIEF.md
# Issue Resource Reservation Timers

This block keeps the short-term occupancy state of the shared execution resources that a SIMD touches when it issues an instruction. Each issue strobe carries an operation class, the issuing SIMD, the owning wavefront and, for flat accesses, whether the address resolved to the shared (local) segment. From these the block loads down-counting busy timers:

- one ALU pipeline timer per SIMD;
- one issue-slot timer per SIMD;
- one issue-slot timer for the global memory unit and one for the local memory unit;
- one timer for each register-file-to-global-memory bus;
- one timer for each register-file-to-local-memory bus.

A timer reads as free once it has counted down to zero. The busy flags feed the readiness logic that decides the next issue.

The block also keeps per-wavefront counts of memory requests in flight. There are five counts: a total, global reads, global writes, local reads and local writes. An issue raises them. A completion strobe with a counter-select mask lowers them. A decrement of a count that is already zero leaves it at zero and raises an error pulse. A count that is already at its maximum value holds on a further increment.

Top module: `issue_res_timers`

## Requirements
- R1: After a synchronous active-low reset, every busy flag is low, every counter reads zero and `cnt_underflow` is low.
- R2: Op codes 0 to 4 (ALU, special, branch, return, kernel argument) load the issuing SIMD's ALU timer with BYPASS_LEN and its issue-slot timer with ISSUE_PERIOD. The flags are high for exactly that many cycles after the issuing edge.
- R3: A barrier (op code 5) loads only the issuing SIMD's issue-slot timer with ISSUE_PERIOD and leaves that SIMD's ALU timer untouched.
- R4: A read (op codes 6 global, 9 private, 12 local, 15 flat) keeps its selected bus busy for RD_HOLD (4) cycles.
- R5: A write or atomic (op codes 7, 8, 10, 11, 13, 14, 16) keeps its selected bus busy for WR_HOLD (8) cycles.
- R6: Every memory op code (6 to 16) raises the wavefront's total count by one. A read raises the matching read count, a write raises the matching write count, and an atomic raises both.
- R7: Private ops (9 to 11) use the global read and write counts, a global bus and the global unit slot.
- R8: A flat read (15) or flat write (16) uses a local bus and the local unit slot when `iss_flat_shared` is high, and a global bus and the global unit slot otherwise. In both cases it raises the global read or write count.
- R9: Every memory issue loads the issue-slot timer of the unit it uses with ISSUE_PERIOD.
- R10: Global and local buses are each chosen round-robin, starting at index 0 after reset. Each group's pointer advances by one only on an issue that uses that group.
- R11: A completion lowers by one each count of `cmp_wf` whose bit is set in `cmp_sel` (bit 0 total, 1 global read, 2 global write, 3 local read, 4 local write). When an issue and a completion hit the same count in the same cycle, the count is unchanged.
- R12: A completion against a count of zero with no matching increment leaves the count at zero. It makes `cnt_underflow` high for the single cycle after that edge.
- R13: Op codes 17 to 31 change no timer, no counter and no bus pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue strobe |
| iss_simd | input | SW (2) | Issuing SIMD index |
| iss_wf | input | WW (2) | Wavefront owning the issue |
| iss_op | input | 5 | Operation class code |
| iss_flat_shared | input | 1 | Flat access resolved to the shared segment |
| cmp_valid | input | 1 | Completion strobe |
| cmp_wf | input | WW (2) | Wavefront of the completion |
| cmp_sel | input | 5 | Counters to lower |
| alu_busy | output | NUM_SIMD (4) | ALU pipeline busy per SIMD |
| simd_slot_busy | output | NUM_SIMD (4) | Issue slot busy per SIMD |
| gmem_slot_busy | output | 1 | Global unit issue slot busy |
| lmem_slot_busy | output | 1 | Local unit issue slot busy |
| gbus_busy | output | NUM_GBUS (2) | Global bus busy per bus |
| lbus_busy | output | NUM_LBUS (2) | Local bus busy per bus |
| cnt_total | output | NUM_WF*CW (16) | Total in-flight count, CW bits per wavefront |
| cnt_rd_gm | output | NUM_WF*CW (16) | Global read count per wavefront |
| cnt_wr_gm | output | NUM_WF*CW (16) | Global write count per wavefront |
| cnt_rd_lm | output | NUM_WF*CW (16) | Local read count per wavefront |
| cnt_wr_lm | output | NUM_WF*CW (16) | Local write count per wavefront |
| cnt_underflow | output | 1 | One-cycle pulse on a decrement below zero |

## Verification
An issue and a completion can land on the same wavefront's count in the same clock. When both hit one count, it must stay put. When only the completion hits a count that is at zero, the count must stay at zero and the error pulse must appear.

Directed steps provoke both cases:
- an atomic is issued while the same counts are being retired;
- a completion targets an idle wavefront.

The random phase then drives issues and completions with independent random wavefronts and masks, so that collisions happen often. Every cycle, each counter and the error flag are compared with a bench model written from the increment and decrement rules.

// File: rtl/irt_pkg.sv
// Shared types for the issue resource reservation timers.
// Assumes one issue and one completion at most per cycle.
package irt_pkg;

    typedef enum logic [4:0] {
        OPC_ALU     = 5'd0,
        OPC_SPECIAL = 5'd1,
        OPC_BRANCH  = 5'd2,
        OPC_RETURN  = 5'd3,
        OPC_KARG    = 5'd4,
        OPC_BARRIER = 5'd5,
        OPC_GLB_RD  = 5'd6,
        OPC_GLB_WR  = 5'd7,
        OPC_GLB_AT  = 5'd8,
        OPC_PRV_RD  = 5'd9,
        OPC_PRV_WR  = 5'd10,
        OPC_PRV_AT  = 5'd11,
        OPC_LOC_RD  = 5'd12,
        OPC_LOC_WR  = 5'd13,
        OPC_LOC_AT  = 5'd14,
        OPC_FLAT_RD = 5'd15,
        OPC_FLAT_WR = 5'd16
    } op_class_e;

    // Counter kinds; the index is also the bit of the completion mask.
    localparam int NUM_KINDS  = 5;
    localparam int KIND_TOTAL = 0;
    localparam int KIND_RD_GM = 1;
    localparam int KIND_WR_GM = 2;
    localparam int KIND_RD_LM = 3;
    localparam int KIND_WR_LM = 4;

    typedef struct packed {
        logic                 alu_ld;     // load SIMD ALU timer
        logic                 simd_ld;    // load SIMD issue slot timer
        logic                 mem;        // memory issue: unit slot + bus
        logic                 use_local;  // local bus and local unit
        logic                 long_hold;  // write/atomic bus hold
        logic [NUM_KINDS-1:0] inc;        // counters to raise
    } issue_ctl_t;

endpackage

// File: rtl/irt_decode.sv
// Operation class decoder: turns the op code and the flat segment flag
// into the set of resource loads and counter increments for one issue.
// Assumes: codes outside the defined classes produce no action.
module irt_decode
    import irt_pkg::*;
(
    input  logic [4:0]  op,
    input  logic        flat_shared,
    output issue_ctl_t  ctl
);

    // Map each class to its resource actions.
    always_comb begin
        ctl = '0;
        case (op_class_e'(op))
            OPC_ALU, OPC_SPECIAL, OPC_BRANCH, OPC_RETURN, OPC_KARG: begin
                ctl.alu_ld  = 1'b1;
                ctl.simd_ld = 1'b1;
            end
            OPC_BARRIER: begin
                ctl.simd_ld = 1'b1;
            end
            OPC_GLB_RD, OPC_PRV_RD: begin
                ctl.mem = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_RD_GM] = 1'b1;
            end
            OPC_GLB_WR, OPC_PRV_WR: begin
                ctl.mem = 1'b1;
                ctl.long_hold = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_WR_GM] = 1'b1;
            end
            OPC_GLB_AT, OPC_PRV_AT: begin
                ctl.mem = 1'b1;
                ctl.long_hold = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_RD_GM] = 1'b1;
                ctl.inc[KIND_WR_GM] = 1'b1;
            end
            OPC_LOC_RD: begin
                ctl.mem = 1'b1;
                ctl.use_local = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_RD_LM] = 1'b1;
            end
            OPC_LOC_WR: begin
                ctl.mem = 1'b1;
                ctl.use_local = 1'b1;
                ctl.long_hold = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_WR_LM] = 1'b1;
            end
            OPC_LOC_AT: begin
                ctl.mem = 1'b1;
                ctl.use_local = 1'b1;
                ctl.long_hold = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_RD_LM] = 1'b1;
                ctl.inc[KIND_WR_LM] = 1'b1;
            end
            OPC_FLAT_RD: begin
                ctl.mem = 1'b1;
                ctl.use_local = flat_shared;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_RD_GM] = 1'b1;
            end
            OPC_FLAT_WR: begin
                ctl.mem = 1'b1;
                ctl.use_local = flat_shared;
                ctl.long_hold = 1'b1;
                ctl.inc[KIND_TOTAL] = 1'b1;
                ctl.inc[KIND_WR_GM] = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/irt_timer.sv
// Down-counting busy timer. A load sets the count (and wins over the
// decrement); the timer reads busy while the count is non-zero.
// Assumes load_val fits in TW bits.
module irt_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy
);

    logic [TW-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/irt_rr_ptr.sv
// Round-robin index over N resources; advances by one on each use and
// wraps after N-1. Assumes PW is wide enough to hold N-1.
module irt_rr_ptr #(
    parameter int N  = 2,
    parameter int PW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] sel
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    // Step the pointer on every use.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel <= '0;
        else if (adv)        sel <= (sel == LAST) ? '0 : sel + PW'(1);
    end

endmodule

// File: rtl/irt_wf_counters.sv
// Per-wavefront in-flight request counters, NUM_KINDS per wavefront.
// An increment and a decrement on the same counter cancel; a decrement
// at zero saturates and raises a one-cycle error pulse; an increment at
// the maximum holds. Assumes one issue and one completion per cycle.
module irt_wf_counters
    import irt_pkg::*;
#(
    parameter int NUM_WF = 4,
    parameter int WW     = 2,
    parameter int CW     = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   inc_en,
    input  logic [WW-1:0]                          inc_wf,
    input  logic [NUM_KINDS-1:0]                   inc_vec,
    input  logic                                   dec_en,
    input  logic [WW-1:0]                          dec_wf,
    input  logic [NUM_KINDS-1:0]                   dec_vec,
    output logic [NUM_WF-1:0][NUM_KINDS-1:0][CW-1:0] cnt,
    output logic                                   uf_q
);

    localparam logic [CW-1:0] CMAX = '1;

    logic [NUM_WF-1:0][NUM_KINDS-1:0] uf_hit;

    for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            logic          up;
            logic          dn;
            logic [CW-1:0] c_q;

            // Select this counter's increment and decrement.
            always_comb begin
                up = inc_en && (inc_wf == WW'(w)) && inc_vec[k];
                dn = dec_en && (dec_wf == WW'(w)) && dec_vec[k];
            end

            // Saturating up/down count.
            always_ff @(posedge clk) begin
                if (!rst_n)                          c_q <= '0;
                else if (up && !dn && c_q != CMAX)   c_q <= c_q + CW'(1);
                else if (dn && !up && c_q != '0)     c_q <= c_q - CW'(1);
            end

            assign uf_hit[w][k] = dn && !up && (c_q == '0);
            assign cnt[w][k]    = c_q;
        end
    end

    // Register the underflow event as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) uf_q <= 1'b0;
        else        uf_q <= |uf_hit;
    end

endmodule

// File: rtl/issue_res_timers.sv
// Issue resource reservation timers. On each issue it loads the busy
// timers of the ALU pipe, issue slots and register-file-to-memory buses
// that the operation class occupies, and keeps per-wavefront in-flight
// request counts. Assumes the readiness logic only issues when the
// needed resources read free; a load onto a busy timer simply reloads it.
module issue_res_timers
    import irt_pkg::*;
#(
    parameter int NUM_SIMD     = 4,
    parameter int NUM_WF       = 4,
    parameter int NUM_GBUS     = 2,
    parameter int NUM_LBUS     = 2,
    parameter int CW           = 4,
    parameter int BYPASS_LEN   = 4,
    parameter int ISSUE_PERIOD = 4,
    parameter int RD_HOLD      = 4,
    parameter int WR_HOLD      = 8,
    localparam int SW  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
    localparam int WW  = (NUM_WF   > 1) ? $clog2(NUM_WF)   : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [SW-1:0]        iss_simd,
    input  logic [WW-1:0]        iss_wf,
    input  logic [4:0]           iss_op,
    input  logic                 iss_flat_shared,
    input  logic                 cmp_valid,
    input  logic [WW-1:0]        cmp_wf,
    input  logic [4:0]           cmp_sel,
    output logic [NUM_SIMD-1:0]  alu_busy,
    output logic [NUM_SIMD-1:0]  simd_slot_busy,
    output logic                 gmem_slot_busy,
    output logic                 lmem_slot_busy,
    output logic [NUM_GBUS-1:0]  gbus_busy,
    output logic [NUM_LBUS-1:0]  lbus_busy,
    output logic [NUM_WF*CW-1:0] cnt_total,
    output logic [NUM_WF*CW-1:0] cnt_rd_gm,
    output logic [NUM_WF*CW-1:0] cnt_wr_gm,
    output logic [NUM_WF*CW-1:0] cnt_rd_lm,
    output logic [NUM_WF*CW-1:0] cnt_wr_lm,
    output logic                 cnt_underflow
);

    localparam int MAX_AB = (BYPASS_LEN > ISSUE_PERIOD) ? BYPASS_LEN : ISSUE_PERIOD;
    localparam int MAX_RW = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
    localparam int MAXL   = (MAX_AB > MAX_RW) ? MAX_AB : MAX_RW;
    localparam int TW     = $clog2(MAXL + 1);
    localparam int GPW    = (NUM_GBUS > 1) ? $clog2(NUM_GBUS) : 1;
    localparam int LPW    = (NUM_LBUS > 1) ? $clog2(NUM_LBUS) : 1;

    localparam logic [TW-1:0] T_BYP  = TW'(BYPASS_LEN);
    localparam logic [TW-1:0] T_ISS  = TW'(ISSUE_PERIOD);
    localparam logic [TW-1:0] T_RD   = TW'(RD_HOLD);
    localparam logic [TW-1:0] T_WR   = TW'(WR_HOLD);

    issue_ctl_t     ctl;
    logic           g_use;
    logic           l_use;
    logic [TW-1:0]  bus_len;
    logic [GPW-1:0] gsel;
    logic [LPW-1:0] lsel;
    logic [NUM_WF-1:0][NUM_KINDS-1:0][CW-1:0] cnt;

    irt_decode u_dec (
        .op          (iss_op),
        .flat_shared (iss_flat_shared),
        .ctl         (ctl)
    );

    // Which memory side this issue occupies and for how long.
    always_comb begin
        g_use   = iss_valid && ctl.mem && !ctl.use_local;
        l_use   = iss_valid && ctl.mem &&  ctl.use_local;
        bus_len = ctl.long_hold ? T_WR : T_RD;
    end

    // Per-SIMD ALU pipe and issue slot timers.
    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
        logic hit;
        assign hit = iss_valid && (iss_simd == SW'(s));

        irt_timer #(.TW(TW)) u_alu (
            .clk (clk), .rst_n (rst_n),
            .load (hit && ctl.alu_ld), .load_val (T_BYP),
            .busy (alu_busy[s])
        );

        irt_timer #(.TW(TW)) u_slot (
            .clk (clk), .rst_n (rst_n),
            .load (hit && ctl.simd_ld), .load_val (T_ISS),
            .busy (simd_slot_busy[s])
        );
    end

    // Memory unit issue slot timers.
    irt_timer #(.TW(TW)) u_gslot (
        .clk (clk), .rst_n (rst_n),
        .load (g_use), .load_val (T_ISS),
        .busy (gmem_slot_busy)
    );

    irt_timer #(.TW(TW)) u_lslot (
        .clk (clk), .rst_n (rst_n),
        .load (l_use), .load_val (T_ISS),
        .busy (lmem_slot_busy)
    );

    // Round-robin bus pickers.
    irt_rr_ptr #(.N(NUM_GBUS), .PW(GPW)) u_gptr (
        .clk (clk), .rst_n (rst_n), .adv (g_use), .sel (gsel)
    );

    irt_rr_ptr #(.N(NUM_LBUS), .PW(LPW)) u_lptr (
        .clk (clk), .rst_n (rst_n), .adv (l_use), .sel (lsel)
    );

    // Global bus timers.
    for (genvar b = 0; b < NUM_GBUS; b++) begin : g_gbus
        irt_timer #(.TW(TW)) u_bus (
            .clk (clk), .rst_n (rst_n),
            .load (g_use && (gsel == GPW'(b))), .load_val (bus_len),
            .busy (gbus_busy[b])
        );
    end

    // Local bus timers.
    for (genvar b = 0; b < NUM_LBUS; b++) begin : g_lbus
        irt_timer #(.TW(TW)) u_bus (
            .clk (clk), .rst_n (rst_n),
            .load (l_use && (lsel == LPW'(b))), .load_val (bus_len),
            .busy (lbus_busy[b])
        );
    end

    irt_wf_counters #(.NUM_WF(NUM_WF), .WW(WW), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (iss_valid),
        .inc_wf  (iss_wf),
        .inc_vec (ctl.inc),
        .dec_en  (cmp_valid),
        .dec_wf  (cmp_wf),
        .dec_vec (cmp_sel),
        .cnt     (cnt),
        .uf_q    (cnt_underflow)
    );

    // Flatten the counter bank onto the output buses.
    for (genvar w = 0; w < NUM_WF; w++) begin : g_out
        assign cnt_total[w*CW +: CW] = cnt[w][KIND_TOTAL];
        assign cnt_rd_gm[w*CW +: CW] = cnt[w][KIND_RD_GM];
        assign cnt_wr_gm[w*CW +: CW] = cnt[w][KIND_WR_GM];
        assign cnt_rd_lm[w*CW +: CW] = cnt[w][KIND_RD_LM];
        assign cnt_wr_lm[w*CW +: CW] = cnt[w][KIND_WR_LM];
    end

endmodule

// File: rtl/irt_checker.sv
// Port-level checker for issue_res_timers, attached with bind.
// Assumes BYPASS_LEN and ISSUE_PERIOD are non-zero.
module irt_checker
    import irt_pkg::*;
#(
    parameter int NUM_SIMD = 4,
    parameter int NUM_WF   = 4,
    parameter int NUM_GBUS = 2,
    parameter int NUM_LBUS = 2,
    parameter int CW       = 4,
    parameter int SW       = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [SW-1:0]        iss_simd,
    input logic [4:0]           iss_op,
    input logic                 iss_flat_shared,
    input logic                 cmp_valid,
    input logic [NUM_SIMD-1:0]  alu_busy,
    input logic [NUM_SIMD-1:0]  simd_slot_busy,
    input logic                 gmem_slot_busy,
    input logic                 lmem_slot_busy,
    input logic [NUM_GBUS-1:0]  gbus_busy,
    input logic [NUM_LBUS-1:0]  lbus_busy,
    input logic [NUM_WF*CW-1:0] cnt_total,
    input logic [NUM_WF*CW-1:0] cnt_rd_gm,
    input logic [NUM_WF*CW-1:0] cnt_wr_gm,
    input logic [NUM_WF*CW-1:0] cnt_rd_lm,
    input logic [NUM_WF*CW-1:0] cnt_wr_lm,
    input logic                 cnt_underflow
);

    logic simd_ok;
    logic alu_like;
    logic glb_read;
    logic mem_op;
    logic [5*NUM_WF*CW-1:0] all_cnt;

    // Classify the op code independently of the decoder.
    always_comb begin
        simd_ok  = (32'(iss_simd) < NUM_SIMD);
        alu_like = (iss_op <= 5'd4);
        glb_read = (iss_op == 5'd6) || (iss_op == 5'd9);
        mem_op   = (iss_op >= 5'd6) && (iss_op <= 5'd16);
        all_cnt  = {cnt_total, cnt_rd_gm, cnt_wr_gm, cnt_rd_lm, cnt_wr_lm};
    end

    AST_ALU_LOADS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && alu_like && simd_ok |=> alu_busy[$past(iss_simd)] && simd_slot_busy[$past(iss_simd)]); // R2

    AST_BARRIER_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_op == 5'd5 && simd_ok && !alu_busy[iss_simd]
        |=> simd_slot_busy[$past(iss_simd)] && !alu_busy[$past(iss_simd)]); // R3

    AST_GLB_READ_RES: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && glb_read |=> (|gbus_busy) && gmem_slot_busy); // R7

    AST_FLAT_SHARED_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_op == 5'd15 && iss_flat_shared |=> (|lbus_busy) && lmem_slot_busy); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid && !(iss_valid && mem_op) |=> $stable(all_cnt)); // R11

    AST_UF_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_underflow |-> $past(cmp_valid)); // R12

    AST_UNDEF_NO_GBUS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_op > 5'd16 && !(|gbus_busy) |=> !(|gbus_busy)); // R13

endmodule

bind issue_res_timers irt_checker #(
    .NUM_SIMD (NUM_SIMD),
    .NUM_WF   (NUM_WF),
    .NUM_GBUS (NUM_GBUS),
    .NUM_LBUS (NUM_LBUS),
    .CW       (CW),
    .SW       (SW)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .iss_valid       (iss_valid),
    .iss_simd        (iss_simd),
    .iss_op          (iss_op),
    .iss_flat_shared (iss_flat_shared),
    .cmp_valid       (cmp_valid),
    .alu_busy        (alu_busy),
    .simd_slot_busy  (simd_slot_busy),
    .gmem_slot_busy  (gmem_slot_busy),
    .lmem_slot_busy  (lmem_slot_busy),
    .gbus_busy       (gbus_busy),
    .lbus_busy       (lbus_busy),
    .cnt_total       (cnt_total),
    .cnt_rd_gm       (cnt_rd_gm),
    .cnt_wr_gm       (cnt_wr_gm),
    .cnt_rd_lm       (cnt_rd_lm),
    .cnt_wr_lm       (cnt_wr_lm),
    .cnt_underflow   (cnt_underflow)
);

// File: tb/sim_issue_res_timers.sv
// Bench: directed corner cases then seeded random traffic, compared each
// cycle with a model written from the requirements.
module sim_issue_res_timers;

    localparam int NS = 4, NW = 4, NG = 2, NL = 2, CW = 4;
    localparam int BYP = 4, IPER = 4, RDH = 4, WRH = 8, CMAXV = 15;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, iss_valid, iss_flat_shared, cmp_valid;
    logic [1:0]    iss_simd, iss_wf, cmp_wf;
    logic [4:0]    iss_op, cmp_sel;
    logic [NS-1:0] alu_busy, simd_slot_busy;
    logic          gmem_slot_busy, lmem_slot_busy, cnt_underflow;
    logic [NG-1:0] gbus_busy;
    logic [NL-1:0] lbus_busy;
    logic [NW*CW-1:0] cnt_total, cnt_rd_gm, cnt_wr_gm, cnt_rd_lm, cnt_wr_lm;

    issue_res_timers u0 (
        .clk (clk), .rst_n (rst_n),
        .iss_valid (iss_valid), .iss_simd (iss_simd), .iss_wf (iss_wf),
        .iss_op (iss_op), .iss_flat_shared (iss_flat_shared),
        .cmp_valid (cmp_valid), .cmp_wf (cmp_wf), .cmp_sel (cmp_sel),
        .alu_busy (alu_busy), .simd_slot_busy (simd_slot_busy),
        .gmem_slot_busy (gmem_slot_busy), .lmem_slot_busy (lmem_slot_busy),
        .gbus_busy (gbus_busy), .lbus_busy (lbus_busy),
        .cnt_total (cnt_total), .cnt_rd_gm (cnt_rd_gm), .cnt_wr_gm (cnt_wr_gm),
        .cnt_rd_lm (cnt_rd_lm), .cnt_wr_lm (cnt_wr_lm),
        .cnt_underflow (cnt_underflow)
    );

    int m_alu[NS], m_sslot[NS], m_gbus[NG], m_lbus[NL];
    int m_gslot, m_lslot, gptr, lptr;
    int m_cnt[NW][5];
    bit m_uf;
    int checks = 0, fails = 0;
    string req = "R1";

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_alu[i] = 0; m_sslot[i] = 0; end
        for (int i = 0; i < NG; i++) m_gbus[i] = 0;
        for (int i = 0; i < NL; i++) m_lbus[i] = 0;
        m_gslot = 0; m_lslot = 0; gptr = 0; lptr = 0; m_uf = 0;
        for (int w = 0; w < NW; w++) for (int k = 0; k < 5; k++) m_cnt[w][k] = 0;
    endtask

    // Next state of the model from the current inputs.
    task automatic model_step();
        bit alu_ld = 0, sl_ld = 0, mem = 0, loc = 0, lng = 0;
        bit [4:0] inc = '0;
        if (iss_valid) begin
            if (iss_op <= 4) begin alu_ld = 1; sl_ld = 1; end
            else if (iss_op == 5) sl_ld = 1;
            else if (iss_op <= 16) begin
                mem = 1; inc[0] = 1;
                case (iss_op)
                    6, 9:   inc[1] = 1;
                    7, 10:  begin inc[2] = 1; lng = 1; end
                    8, 11:  begin inc[1] = 1; inc[2] = 1; lng = 1; end
                    12:     begin inc[3] = 1; loc = 1; end
                    13:     begin inc[4] = 1; loc = 1; lng = 1; end
                    14:     begin inc[3] = 1; inc[4] = 1; loc = 1; lng = 1; end
                    15:     begin inc[1] = 1; loc = iss_flat_shared; end
                    default: begin inc[2] = 1; loc = iss_flat_shared; lng = 1; end
                endcase
            end
        end
        for (int i = 0; i < NS; i++) begin
            if (m_alu[i] > 0) m_alu[i]--;
            if (m_sslot[i] > 0) m_sslot[i]--;
        end
        for (int i = 0; i < NG; i++) if (m_gbus[i] > 0) m_gbus[i]--;
        for (int i = 0; i < NL; i++) if (m_lbus[i] > 0) m_lbus[i]--;
        if (m_gslot > 0) m_gslot--;
        if (m_lslot > 0) m_lslot--;
        if (alu_ld) m_alu[iss_simd] = BYP;
        if (sl_ld)  m_sslot[iss_simd] = IPER;
        if (mem && loc) begin
            m_lslot = IPER; m_lbus[lptr] = lng ? WRH : RDH; lptr = (lptr + 1) % NL;
        end else if (mem) begin
            m_gslot = IPER; m_gbus[gptr] = lng ? WRH : RDH; gptr = (gptr + 1) % NG;
        end
        m_uf = 0;
        for (int w = 0; w < NW; w++) begin
            for (int k = 0; k < 5; k++) begin
                bit up, dn;
                up = iss_valid && (iss_wf == w) && inc[k];
                dn = cmp_valid && (cmp_wf == w) && cmp_sel[k];
                if (up && !dn) begin
                    if (m_cnt[w][k] < CMAXV) m_cnt[w][k]++;
                end else if (dn && !up) begin
                    if (m_cnt[w][k] == 0) m_uf = 1;
                    else m_cnt[w][k]--;
                end
            end
        end
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW*CW-1:0] pack_cnt(int k);
        logic [NW*CW-1:0] v = '0;
        for (int w = 0; w < NW; w++) v[w*CW +: CW] = CW'(m_cnt[w][k]);
        return v;
    endfunction

    task automatic compare();
        logic [NS-1:0] ea = '0, es = '0;
        logic [NG-1:0] eg = '0;
        logic [NL-1:0] el = '0;
        for (int i = 0; i < NS; i++) begin ea[i] = m_alu[i] > 0; es[i] = m_sslot[i] > 0; end
        for (int i = 0; i < NG; i++) eg[i] = m_gbus[i] > 0;
        for (int i = 0; i < NL; i++) el[i] = m_lbus[i] > 0;
        chk("alu_busy", 64'(alu_busy), 64'(ea));
        chk("simd_slot_busy", 64'(simd_slot_busy), 64'(es));
        chk("slots g/l", {62'd0, gmem_slot_busy, lmem_slot_busy}, {62'd0, m_gslot > 0, m_lslot > 0});
        chk("gbus_busy", 64'(gbus_busy), 64'(eg));
        chk("lbus_busy", 64'(lbus_busy), 64'(el));
        chk("cnt_total", 64'(cnt_total), 64'(pack_cnt(0)));
        chk("cnt_rd_gm", 64'(cnt_rd_gm), 64'(pack_cnt(1)));
        chk("cnt_wr_gm", 64'(cnt_wr_gm), 64'(pack_cnt(2)));
        chk("cnt_rd_lm", 64'(cnt_rd_lm), 64'(pack_cnt(3)));
        chk("cnt_wr_lm", 64'(cnt_wr_lm), 64'(pack_cnt(4)));
        chk("cnt_underflow", 64'(cnt_underflow), 64'(m_uf));
    endtask

    task automatic idle_inputs();
        iss_valid = 0; iss_simd = 0; iss_wf = 0; iss_op = 0; iss_flat_shared = 0;
        cmp_valid = 0; cmp_wf = 0; cmp_sel = 0;
    endtask

    // One clock: model, edge, sample at the falling edge.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic issue(int op, int simd, int wf, bit sh);
        iss_valid = 1; iss_op = 5'(op); iss_simd = 2'(simd); iss_wf = 2'(wf);
        iss_flat_shared = sh;
        cycle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R1"; compare();

        req = "R2"; issue(0, 1, 0, 0); idle(6);
        req = "R2"; issue(3, 3, 0, 0); idle(5);
        req = "R3"; issue(5, 2, 0, 0); idle(5);
        req = "R4"; issue(6, 0, 0, 0); idle(5);
        req = "R5"; issue(7, 0, 1, 0); idle(9);
        req = "R6"; issue(14, 0, 2, 0); idle(9);
        req = "R7"; issue(9, 0, 3, 0); issue(11, 1, 3, 0); idle(9);
        req = "R8"; issue(15, 0, 1, 1); issue(16, 0, 1, 0); idle(9);
        req = "R9"; issue(12, 0, 0, 0); idle(5);
        req = "R10"; issue(6, 0, 0, 0); issue(6, 0, 0, 0); issue(6, 0, 0, 0); idle(5);
        req = "R13"; issue(20, 0, 0, 0); issue(31, 1, 2, 1); idle(2);
        req = "R11";
        cmp_valid = 1; cmp_wf = 2; cmp_sel = 5'b11001; cycle();
        iss_valid = 1; iss_op = 5'd8; iss_wf = 2'd3; cmp_valid = 1; cmp_wf = 2'd3; cmp_sel = 5'b00111;
        cycle(); idle(9);
        req = "R12";
        cmp_valid = 1; cmp_wf = 2'd0; cmp_sel = 5'b10000; cycle();
        cmp_valid = 1; cmp_wf = 2'd2; cmp_sel = 5'b11111; cycle();
        idle(2);

        req = "R6";
        for (int n = 0; n < 3000; n++) begin
            iss_valid = ($urandom % 2) == 0;
            iss_op = 5'($urandom % 20);
            iss_simd = 2'($urandom % NS);
            iss_wf = 2'($urandom % NW);
            iss_flat_shared = 1'($urandom % 2);
            cmp_valid = ($urandom % 5) < 2;
            cmp_wf = 2'($urandom % NW);
            cmp_sel = 5'($urandom);
            cycle();
        end
        finish_run();
    end

endmodule